// File: doc/BRIEF.md
# UART host buffer and status interface

This block is the register-facing front end of a UART. A processor talks to it over a small bus with a one-bit address, a read strobe, a write strobe and 8-bit data. Address 0 is the data location and address 1 is the status location. At the data location, writes and reads reach two different stores. A write fills a one-byte transmit holding buffer. A read returns, and consumes, the oldest character in a two-entry receive queue.

The serial engines are outside the block. The transmit engine reports whether its shift register is idle and pulses when a frame has fully left it. When the block hands it a byte, it does so with a one-cycle load strobe. The receive engine pulses once per completed character, with the character and its frame and parity error indications.

The status byte combines three flags: receive complete, transmit complete and data register empty. It also shows the error bits of the character at the head of the queue, an overrun indication, and two mode bits that software can write. Each of the three flags drives an interrupt request line through its own enable input. An acknowledge pulse clears the transmit-complete flag.

Top module: `uart_host_regs`

## Requirements
- R1: A write with address 0 loads the transmit holding buffer and clears the empty flag (status bit 5). The data is read combinationally from the current state: with address 0 it is the head of the receive queue, or 0 when the queue is empty. With address 1 it is the status byte.
- R2: A write with address 0 while status bit 5 is 0 is discarded, and the buffer keeps the byte it already held.
- R3: In any cycle where `tx_en` is 1, the buffer is full and `txs_idle` is 1, `txs_load` is 1 and `txs_data` carries the buffered byte. From the next cycle on, status bit 5 reads 1 again.
- R4: The receive queue holds two characters in arrival order. Every read strobe with address 0 removes the head entry if there is one. Reads with address 1 remove nothing.
- R5: `chr_size` selects 5, 6, 7 or 8 data bits (encodings 0, 1, 2, 3). Bits above the selected size are forced to 0, both in `txs_data` and in the characters stored in the receive queue.
- R6: Status bit 7 (receive complete) is 1 exactly while the receive queue holds at least one entry.
- R7: While `rx_en` is 0, the receive queue is emptied and arriving characters are ignored.
- R8: Status bit 6 (transmit complete) sets when `txs_done` pulses while the buffer is empty. It clears on `txc_ack`, or on a write to address 1 with data bit 6 set. If a set and a clear fall in the same cycle, the set wins.
- R9: Status bit 5 reads 1 after reset, and writes to address 1 never change it or the bits 7, 4, 3 and 2.
- R10: Status bits 4 (frame error) and 2 (parity error) show the flags stored with the head entry, and read 0 when the queue is empty. Bits 1 and 0 are written from data bits 1 and 0 by a write to address 1, and drive `mode_dbl` and `mode_mpm`. The status byte resets to 0x20.
- R11: A character that arrives while both entries are full, with no read removing the head in that same cycle, is dropped. The newest stored entry is then marked with overrun, and status bit 3 shows 1 while that entry is at the head.
- R12: `irq_rxc`, `irq_txc` and `irq_dre` are status bits 7, 6 and 5 respectively, each ANDed with its enable input `rxc_ie`, `txc_ie` or `dre_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = data location, 1 = status location |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| chr_size | input | 2 | Character size: 0..3 = 5..8 bits |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| txs_load | output | 1 | Hands the buffered byte to the shift register |
| txs_data | output | 8 | Byte being handed over, masked to size |
| txs_idle | input | 1 | Transmit shift register is empty |
| txs_done | input | 1 | Pulse: a frame has fully left the shift register |
| rxe_valid | input | 1 | Pulse: a received character is ready |
| rxe_data | input | 8 | Received character |
| rxe_ferr | input | 1 | Frame error of that character |
| rxe_perr | input | 1 | Parity error of that character |
| mode_dbl | output | 1 | Double-speed mode bit |
| mode_mpm | output | 1 | Multiprocessor mode bit |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| txc_ie | input | 1 | Transmit-complete interrupt enable |
| dre_ie | input | 1 | Data-register-empty interrupt enable |
| txc_ack | input | 1 | Pulse: transmit-complete interrupt acknowledged |
| irq_rxc | output | 1 | Receive-complete request |
| irq_txc | output | 1 | Transmit-complete request |
| irq_dre | output | 1 | Data-register-empty request |

## Verification
Directed patterns cover each edge of the behaviour. A second write to a full buffer tells discard apart from overwrite. Three back-to-back arrivals tell dropping and overrun marking apart from overwriting the oldest entry. A read and an arrival in the same cycle on a full queue tell accept-on-pop apart from a false overrun. Repeated status reads show that only data-address reads consume entries. A simultaneous completion and acknowledge fixes the set-over-clear priority, and size codes 0 and 1 show masking on both paths. A long pseudo-random phase then mixes strobes, enables and sizes, and checks every output against a queue-based reference model on every clock.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] data_t;

    // status byte bit positions
    localparam int ST_RXC = 7;
    localparam int ST_TXC = 6;
    localparam int ST_DRE = 5;
    localparam int ST_FE  = 4;
    localparam int ST_DOR = 3;
    localparam int ST_PE  = 2;
    localparam int ST_DBL = 1;
    localparam int ST_MPM = 0;

    typedef struct packed {
        data_t data;
        logic  ferr;
        logic  perr;
        logic  ovr;
    } rx_entry_t;

    // 0..3 selects 5..8 significant bits
    function automatic data_t size_mask(input logic [1:0] sz);
        return data_t'({DATA_W{1'b1}}) >> (2'd3 - sz);
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  data_t      wr_data,
    input  logic       tx_en,
    input  logic       shift_idle,
    input  logic [1:0] chr_size,
    output logic       buf_empty,
    output data_t      buf_data,
    output logic       load,
    output data_t      load_data
);

    typedef struct packed {
        logic  full;
        data_t data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.full = 1'b0;
        end
        if (wr_en && !st_q.full) begin
            st_d.data = wr_data;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load      = tx_en & st_q.full & shift_idle;
    assign load_data = st_q.data & size_mask(chr_size);
    assign buf_empty = ~st_q.full;
    assign buf_data  = st_q.data;

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_host_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  rx_entry_t                    push_entry,
    input  logic                         pop_req,
    input  logic                         flush,
    output rx_entry_t                    head_entry,
    output logic                         not_empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]         head;
        logic [CW-1:0]         count;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  do_pop;
    logic  do_push;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input logic [CW-1:0] n);
        int s;
        s = int'(p) + int'(n);
        if (s >= DEPTH) begin
            s = s - DEPTH;
        end
        return PW'(s);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_req && (st_q.count != '0);
        do_push = push && ((st_q.count != FULL_CNT) || do_pop);
        if (do_push) begin
            st_d.slot[wrap_add(st_q.head, st_q.count)] = push_entry;
        end else if (push) begin
            st_d.slot[wrap_add(st_q.head, st_q.count - 1'b1)].ovr = 1'b1;
        end
        if (do_pop) begin
            st_d.head = wrap_add(st_q.head, CW'(1));
        end
        st_d.count = st_q.count + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            st_d.count = '0;
            st_d.head  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_entry = st_q.slot[st_q.head];
    assign not_empty  = (st_q.count != '0);
    assign level      = st_q.count;

endmodule

// File: rtl/uart_stat_ctl.sv
module uart_stat_ctl
    import uart_host_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stat_wr,
    input  data_t wr_data,
    input  logic  frame_done,
    input  logic  buf_empty,
    input  logic  txc_ack,
    output logic  txc,
    output logic  dbl,
    output logic  mpm
);

    typedef struct packed {
        logic txc;
        logic dbl;
        logic mpm;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_wr) begin
            st_d.dbl = wr_data[ST_DBL];
            st_d.mpm = wr_data[ST_MPM];
            if (wr_data[ST_TXC]) begin
                st_d.txc = 1'b0;
            end
        end
        if (txc_ack) begin
            st_d.txc = 1'b0;
        end
        // a completion in the same cycle as a clear is kept
        if (frame_done && buf_empty) begin
            st_d.txc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txc = st_q.txc;
    assign dbl = st_q.dbl;
    assign mpm = st_q.mpm;

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int RXQ_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [1:0] chr_size,
    input  logic       tx_en,
    input  logic       rx_en,
    output logic       txs_load,
    output logic [7:0] txs_data,
    input  logic       txs_idle,
    input  logic       txs_done,
    input  logic       rxe_valid,
    input  logic [7:0] rxe_data,
    input  logic       rxe_ferr,
    input  logic       rxe_perr,
    output logic       mode_dbl,
    output logic       mode_mpm,
    input  logic       rxc_ie,
    input  logic       txc_ie,
    input  logic       dre_ie,
    input  logic       txc_ack,
    output logic       irq_rxc,
    output logic       irq_txc,
    output logic       irq_dre
);

    localparam int LVW = $clog2(RXQ_DEPTH + 1);

    logic            wr_data_sel;
    logic            wr_stat_sel;
    logic            rd_data_sel;
    logic            dre;
    data_t           hold_data;
    logic            txc;
    logic            rxc;
    rx_entry_t       rx_in;
    rx_entry_t       rx_head;
    logic [LVW-1:0]  rx_level;
    data_t           status;

    assign wr_data_sel = bus_wr & ~bus_addr;
    assign wr_stat_sel = bus_wr &  bus_addr;
    assign rd_data_sel = bus_rd & ~bus_addr;

    uart_tx_hold u_tx_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_data_sel),
        .wr_data    (bus_wdata),
        .tx_en      (tx_en),
        .shift_idle (txs_idle),
        .chr_size   (chr_size),
        .buf_empty  (dre),
        .buf_data   (hold_data),
        .load       (txs_load),
        .load_data  (txs_data)
    );

    always_comb begin
        rx_in      = '0;
        rx_in.data = rxe_data & size_mask(chr_size);
        rx_in.ferr = rxe_ferr;
        rx_in.perr = rxe_perr;
        rx_in.ovr  = 1'b0;
    end

    uart_rx_queue #(
        .DEPTH (RXQ_DEPTH)
    ) u_rx_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rxe_valid & rx_en),
        .push_entry (rx_in),
        .pop_req    (rd_data_sel),
        .flush      (~rx_en),
        .head_entry (rx_head),
        .not_empty  (rxc),
        .level      (rx_level)
    );

    uart_stat_ctl u_stat_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_wr    (wr_stat_sel),
        .wr_data    (bus_wdata),
        .frame_done (txs_done),
        .buf_empty  (dre),
        .txc_ack    (txc_ack),
        .txc        (txc),
        .dbl        (mode_dbl),
        .mpm        (mode_mpm)
    );

    always_comb begin
        status         = '0;
        status[ST_RXC] = rxc;
        status[ST_TXC] = txc;
        status[ST_DRE] = dre;
        status[ST_FE]  = rxc & rx_head.ferr;
        status[ST_DOR] = rxc & rx_head.ovr;
        status[ST_PE]  = rxc & rx_head.perr;
        status[ST_DBL] = mode_dbl;
        status[ST_MPM] = mode_mpm;
        if (bus_addr) begin
            bus_rdata = status;
        end else begin
            bus_rdata = rxc ? rx_head.data : '0;
        end
    end

    assign irq_rxc = rxc & rxc_ie;
    assign irq_txc = txc & txc_ie;
    assign irq_dre = dre & dre_ie;

endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
    parameter int LVW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_addr,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic           tx_en,
    input logic           rx_en,
    input logic           txs_idle,
    input logic           txs_done,
    input logic           rxe_valid,
    input logic           txc_ack,
    input logic           txc_ie,
    input logic           dre_ie,
    input logic           txs_load,
    input logic           irq_txc,
    input logic           irq_dre,
    input logic           dre,
    input logic           txc,
    input logic           rxc,
    input logic [7:0]     hold_data,
    input logic [LVW-1:0] rx_level
);

    AST_DISCARD_FULL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && !dre) |=> $stable(hold_data)); // R2

    AST_LOAD_FREES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        txs_load |=> dre); // R3

    AST_LOAD_CONDITIONS: assert property (@(posedge clk) disable iff (!rst_n)
        txs_load |-> (tx_en && txs_idle && !dre)); // R3

    AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && rx_level == 1 && !rxe_valid) |=> !rxc); // R6

    AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rxc); // R7

    AST_TXC_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (txc_ack && !(txs_done && dre)) |=> !txc); // R8

    AST_TXC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (txs_done && dre) |=> txc); // R8

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= 2); // R11

    AST_DRE_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dre |-> dre_ie); // R12

    AST_TXC_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txc |-> (txc_ie && txc)); // R12

endmodule

bind uart_host_regs uart_host_regs_chk #(
    .LVW (LVW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .txs_idle  (txs_idle),
    .txs_done  (txs_done),
    .rxe_valid (rxe_valid),
    .txc_ack   (txc_ack),
    .txc_ie    (txc_ie),
    .dre_ie    (dre_ie),
    .txs_load  (txs_load),
    .irq_txc   (irq_txc),
    .irq_dre   (irq_dre),
    .dre       (dre),
    .txc       (txc),
    .rxc       (rxc),
    .hold_data (hold_data),
    .rx_level  (rx_level)
);

// File: tb/uart_host_regs_bench.sv
module uart_host_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] chr_size = 2'd3;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       txs_load;
    logic [7:0] txs_data;
    logic       txs_idle = 1'b0;
    logic       txs_done = 1'b0;
    logic       rxe_valid = 1'b0;
    logic [7:0] rxe_data = '0;
    logic       rxe_ferr = 1'b0;
    logic       rxe_perr = 1'b0;
    logic       mode_dbl;
    logic       mode_mpm;
    logic       rxc_ie = 1'b0;
    logic       txc_ie = 1'b0;
    logic       dre_ie = 1'b0;
    logic       txc_ack = 1'b0;
    logic       irq_rxc;
    logic       irq_txc;
    logic       irq_dre;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    bit   m_full = 0;
    int   m_hold = 0;
    bit   m_txc = 0;
    bit   m_dbl = 0;
    bit   m_mpm = 0;
    int   qd[$];
    bit   qf[$];
    bit   qp[$];
    bit   qo[$];

    always #4 clk = ~clk;

    uart_host_regs u_uart_host_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chr_size(chr_size), .tx_en(tx_en), .rx_en(rx_en),
        .txs_load(txs_load), .txs_data(txs_data),
        .txs_idle(txs_idle), .txs_done(txs_done),
        .rxe_valid(rxe_valid), .rxe_data(rxe_data),
        .rxe_ferr(rxe_ferr), .rxe_perr(rxe_perr),
        .mode_dbl(mode_dbl), .mode_mpm(mode_mpm),
        .rxc_ie(rxc_ie), .txc_ie(txc_ie), .dre_ie(dre_ie), .txc_ack(txc_ack),
        .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
    );

    function automatic int bmask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 'h1F;
            2'd1:    return 'h3F;
            2'd2:    return 'h7F;
            default: return 'hFF;
        endcase
    endfunction

    function automatic logic [7:0] m_status();
        logic [7:0] s;
        s = '0;
        if (qd.size() > 0) begin
            s[7] = 1'b1;
            s[4] = qf[0];
            s[3] = qo[0];
            s[2] = qp[0];
        end
        s[6] = m_txc;
        s[5] = !m_full;
        s[1] = m_dbl;
        s[0] = m_mpm;
        return s;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [7:0] exp_rd;
        bit         exp_ld;
        exp_rd = bus_addr ? m_status() : ((qd.size() > 0) ? 8'(qd[0]) : 8'h00);
        exp_ld = tx_en && m_full && txs_idle;
        check(bus_addr ? "R10 status byte" : "R1 R4 data read", bus_rdata, exp_rd);
        check("R3 load strobe", {7'd0, txs_load}, {7'd0, exp_ld});
        if (exp_ld) begin
            check("R5 load data", txs_data, 8'(m_hold & bmask(chr_size)));
        end
        check("R12 irq_rxc", {7'd0, irq_rxc}, {7'd0, (qd.size() > 0) && rxc_ie});
        check("R12 irq_txc", {7'd0, irq_txc}, {7'd0, m_txc && txc_ie});
        check("R12 irq_dre", {7'd0, irq_dre}, {7'd0, !m_full && dre_ie});
        check("R10 mode bits", {6'd0, mode_dbl, mode_mpm}, {6'd0, m_dbl, m_mpm});
    endtask

    task automatic model_clock();
        bit ld;
        bit set_txc;
        bit clr_txc;
        bit pop;
        ld      = tx_en && m_full && txs_idle;
        set_txc = txs_done && !m_full;
        clr_txc = txc_ack || (bus_wr && bus_addr && bus_wdata[6]);
        if (clr_txc) m_txc = 0;
        if (set_txc) m_txc = 1;
        if (bus_wr && bus_addr) begin
            m_dbl = bus_wdata[1];
            m_mpm = bus_wdata[0];
        end
        if (ld) m_full = 0;
        else if (bus_wr && !bus_addr && !m_full) begin
            m_hold = int'(bus_wdata);
            m_full = 1;
        end
        if (!rx_en) begin
            qd.delete(); qf.delete(); qp.delete(); qo.delete();
        end else begin
            pop = bus_rd && !bus_addr && (qd.size() > 0);
            if (pop) begin
                void'(qd.pop_front()); void'(qf.pop_front());
                void'(qp.pop_front()); void'(qo.pop_front());
            end
            if (rxe_valid) begin
                if (qd.size() < 2) begin
                    qd.push_back(int'(rxe_data) & bmask(chr_size));
                    qf.push_back(rxe_ferr);
                    qp.push_back(rxe_perr);
                    qo.push_back(1'b0);
                end else begin
                    qo[qo.size()-1] = 1'b1;
                end
            end
        end
    endtask

    // one clock: compare, register, then release strobes
    task automatic cyc();
        #1;
        compare_all();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; txs_done = 0; rxe_valid = 0; txc_ack = 0;
        rxe_ferr = 0; rxe_perr = 0;
    endtask

    task automatic expect_stat(input string tag, input logic [7:0] exp);
        bus_addr = 1; bus_rd = 1;
        #1 check(tag, bus_rdata, exp);
        cyc();
    endtask

    task automatic expect_data(input string tag, input logic [7:0] exp);
        bus_addr = 0; bus_rd = 1;
        #1 check(tag, bus_rdata, exp);
        cyc();
    endtask

    task automatic push_rx(input logic [7:0] d, input bit fe, input bit pe);
        rxe_valid = 1; rxe_data = d; rxe_ferr = fe; rxe_perr = pe;
        cyc();
    endtask

    task automatic write_reg(input bit a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1; bus_wdata = d;
        cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        expect_stat("R9 R10 reset status", 8'h20);

        // transmit path
        tx_en = 1; txs_idle = 0; chr_size = 2'd3;
        write_reg(0, 8'hA5);
        expect_stat("R1 write clears empty flag", 8'h00);
        write_reg(0, 8'h3C);
        txs_idle = 1;
        #1 check("R3 load strobe when idle", {7'd0, txs_load}, 8'h01);
        check("R2 discarded write kept first byte", txs_data, 8'hA5);
        cyc();
        txs_idle = 0;
        expect_stat("R3 empty flag back after load", 8'h20);

        // transmit complete flag
        txs_done = 1; cyc();
        txc_ie = 1; bus_addr = 1;
        #1 check("R8 done sets txc", bus_rdata, 8'h60);
        check("R12 irq_txc follows flag", {7'd0, irq_txc}, 8'h01);
        cyc();
        write_reg(1, 8'h43);
        expect_stat("R8 R10 one-to-clear and mode bits", 8'h23);
        write_reg(1, 8'hBF);
        expect_stat("R9 read-only bits untouched", 8'h23);
        txs_done = 1; txc_ack = 1; cyc();
        expect_stat("R8 set wins over ack", 8'h63);
        txc_ack = 1; cyc();
        expect_stat("R8 ack clears txc", 8'h23);
        txc_ie = 0;

        // transmit masking
        chr_size = 2'd0;
        write_reg(0, 8'hFF);
        txs_idle = 1;
        #1 check("R5 tx upper bits masked", txs_data, 8'h1F);
        cyc();
        txs_idle = 0;

        // receive queue and overrun
        rx_en = 1; chr_size = 2'd1; rxc_ie = 1;
        push_rx(8'hFF, 0, 0);
        push_rx(8'h81, 1, 0);
        push_rx(8'h55, 0, 0);
        bus_addr = 1;
        #1 check("R12 irq_rxc with data", {7'd0, irq_rxc}, 8'h01);
        cyc();
        expect_stat("R11 head entry clean", 8'hA3);
        expect_stat("R4 status read does not pop", 8'hA3);
        expect_data("R5 rx upper bits zero", 8'h3F);
        expect_stat("R11 overrun on newest entry", 8'hBB);
        expect_data("R4 second entry in order", 8'h01);
        expect_stat("R6 empty clears rxc", 8'h23);
        expect_data("R1 empty read returns zero", 8'h00);

        // pop and push on a full queue in one cycle
        chr_size = 2'd3;
        push_rx(8'h11, 0, 0);
        push_rx(8'h22, 0, 0);
        bus_addr = 0; bus_rd = 1; rxe_valid = 1; rxe_data = 8'h33;
        #1 check("R4 head while full", bus_rdata, 8'h11);
        cyc();
        expect_stat("R11 no overrun when popped", 8'hA3);
        expect_data("R11 kept second", 8'h22);
        expect_data("R11 accepted third", 8'h33);
        expect_stat("R6 drained", 8'h23);

        // flush and ignore while disabled
        push_rx(8'h44, 0, 0);
        rx_en = 0; cyc();
        expect_stat("R7 disable flushes", 8'h23);
        push_rx(8'h77, 0, 0);
        rx_en = 1;
        expect_stat("R7 arrival ignored while disabled", 8'h23);

        // parity flag travels with entry
        push_rx(8'h66, 0, 1);
        expect_stat("R10 parity bit of head", 8'hA7);
        expect_data("R10 parity entry data", 8'h66);

        // mixed pseudo-random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bus_addr  = $urandom_range(1, 0) == 1;
            bus_rd    = $urandom_range(2, 0) == 0;
            bus_wr    = $urandom_range(3, 0) == 0;
            bus_wdata = 8'($urandom());
            tx_en     = $urandom_range(7, 0) != 0;
            rx_en     = $urandom_range(31, 0) != 0;
            txs_idle  = $urandom_range(1, 0) == 1;
            txs_done  = $urandom_range(4, 0) == 0;
            rxe_valid = $urandom_range(2, 0) == 0;
            rxe_data  = 8'($urandom());
            rxe_ferr  = $urandom_range(3, 0) == 0;
            rxe_perr  = $urandom_range(3, 0) == 0;
            txc_ack   = $urandom_range(9, 0) == 0;
            rxc_ie    = $urandom_range(1, 0) == 1;
            txc_ie    = $urandom_range(1, 0) == 1;
            dre_ie    = $urandom_range(1, 0) == 1;
            if ($urandom_range(15, 0) == 0) chr_size = 2'($urandom());
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired (all requirements) act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule